// File: doc/BRIEF.md
# Vectored Interrupt Request Controller

This block sits between eight device interrupt lines and a processor that has one interrupt input. Each device request is captured in a pending register, so requests that arrive together are not lost. The controller raises one request toward the processor whenever something is pending and nothing is being serviced. When the processor acknowledges, the controller picks the lowest-numbered pending line and moves it to an in-service register. On the next cycle it presents that line's 8-bit type number on its vector output.

Only one interrupt is serviced at a time. After an acknowledge, the processor request stays low until software sends an end-of-interrupt pulse. A small write port reprograms the type number of any line. One line (line 2 by default) can act as the cascade input from a second, identical controller. When cascading is enabled and that line is chosen, the vector output takes the secondary controller's type number.

Top module: `vic_top`

## Requirements
- R1: A synchronous reset clears all pending and in-service state and sets `vec_o` to 0 with `irq_o` low. It loads the default type numbers, which are 0x08 plus the line index for every line (line 0 gives 0x08, line 7 gives 0x0F).
- R2: A high level on `req_i[n]` in any clock cycle marks line n pending. With nothing in service, `irq_o` is high from the following cycle.
- R3: Requests that are pending together are all kept. They are serviced in fixed priority order, with the lowest index first.
- R4: An acknowledge (`ack_i` high) in a cycle where `irq_o` is high is accepted. On the next cycle `vec_o` holds the type number of the lowest-index pending line, and that line is no longer pending.
- R5: An acknowledge in a cycle where `irq_o` is low is ignored. `vec_o` and all pending state stay unchanged.
- R6: After an accepted acknowledge, `irq_o` stays low whatever is pending, until an `eoi_i` pulse. From the cycle after `eoi_i`, `irq_o` is high again if any line is pending.
- R7: A cycle with `cfg_we_i` high writes `cfg_vec_i` as the type number of line `cfg_line_i`. The new value is used from the next accepted acknowledge onward.
- R8: When line 2 is accepted with `casc_en_i` high, `vec_o` takes the value of `casc_vec_i` sampled in the acknowledge cycle. With `casc_en_i` low, line 2 uses its own programmed type number.
- R9: `vec_o` changes only on an accepted acknowledge or on reset.
- R10: A request on the same line that is being accepted, arriving in the acknowledge cycle, leaves that line pending again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 8 | Device request lines, level sampled each cycle |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_i | input | 1 | Processor acknowledge |
| vec_o | output | 8 | Type number of the last accepted line |
| eoi_i | input | 1 | End-of-interrupt pulse |
| cfg_we_i | input | 1 | Type number write enable |
| cfg_line_i | input | 3 | Line whose type number is written |
| cfg_vec_i | input | 8 | Type number to write |
| casc_en_i | input | 1 | Line 2 acts as the cascade input |
| casc_vec_i | input | 8 | Type number supplied by the secondary controller |

## Verification
The assertions assume only that reset is held at the first clock edge. They place no limits on `ack_i`, `eoi_i` or the requests: an acknowledge while idle and an end-of-interrupt with nothing in service are both legal and must be harmless. The stimulus holds reset at start-up, then drives directed sequences followed by a long run where every input changes freely. This includes spurious acknowledges, stray end-of-interrupt pulses and writes that land in the same cycle as an accept.

// File: rtl/vic_pkg.sv
package vic_pkg;

  // Reset type number for a line: base plus line index.
  function automatic int default_vector(input int line, input int base);
    return base + line;
  endfunction

  // Index of the lowest set bit, -1 when none is set.
  function automatic int lowest_index(input logic [31:0] v);
    int r;
    r = -1;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/vic_pending.sv
module vic_pending #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  // A new request wins over the clear of an accepted line.
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int N  = 8,
  parameter int LW = 3
) (
  input  logic [N-1:0]  pend_i,
  output logic          valid_o,
  output logic [LW-1:0] idx_o,
  output logic [N-1:0]  onehot_o
);
  logic [N:0] lower;   // lower[i]: some line below i is pending

  assign lower[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_chain
    assign lower[g+1]  = lower[g] | pend_i[g];
    assign onehot_o[g] = pend_i[g] & ~lower[g];
  end

  assign valid_o = lower[N];

  always_comb begin
    idx_o = LW'(vic_pkg::lowest_index(32'(pend_i)));
  end
endmodule

// File: rtl/vic_vtab.sv
module vic_vtab #(
  parameter int N    = 8,
  parameter int VW   = 8,
  parameter int LW   = 3,
  parameter int BASE = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [LW-1:0] waddr_i,
  input  logic [VW-1:0] wdata_i,
  input  logic [LW-1:0] raddr_i,
  output logic [VW-1:0] rdata_o
);
  logic [VW-1:0] tab [N];

  for (genvar g = 0; g < N; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)
        tab[g] <= VW'(vic_pkg::default_vector(g, BASE));
      else if (we_i && (int'(waddr_i) == g))
        tab[g] <= wdata_i;
    end
  end

  assign rdata_o = tab[raddr_i];
endmodule

// File: rtl/vic_top.sv
module vic_top #(
  parameter int N_LINES   = 8,
  parameter int VEC_W     = 8,
  parameter int CASC_LINE = 2,
  parameter int VEC_BASE  = 8,
  localparam int LW       = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] req_i,
  output logic               irq_o,
  input  logic               ack_i,
  output logic [VEC_W-1:0]   vec_o,
  input  logic               eoi_i,
  input  logic               cfg_we_i,
  input  logic [LW-1:0]      cfg_line_i,
  input  logic [VEC_W-1:0]   cfg_vec_i,
  input  logic               casc_en_i,
  input  logic [VEC_W-1:0]   casc_vec_i
);
  logic [N_LINES-1:0] pend_q;
  logic [N_LINES-1:0] isr_q;
  logic [N_LINES-1:0] sel_oh;
  logic [LW-1:0]      sel_idx;
  logic               sel_vld;
  logic               busy;
  logic               accept;     // acknowledge taken this cycle
  logic               casc_hit;   // accepted line is the cascade input
  logic [N_LINES-1:0] pend_clr;
  logic [VEC_W-1:0]   tab_vec;
  logic [VEC_W-1:0]   next_vec;
  logic [VEC_W-1:0]   vec_q;

  vic_pending #(.N(N_LINES)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .set_i  (req_i),
    .clr_i  (pend_clr),
    .pend_o (pend_q)
  );

  vic_prio #(.N(N_LINES), .LW(LW)) u_prio (
    .pend_i   (pend_q),
    .valid_o  (sel_vld),
    .idx_o    (sel_idx),
    .onehot_o (sel_oh)
  );

  vic_vtab #(.N(N_LINES), .VW(VEC_W), .LW(LW), .BASE(VEC_BASE)) u_vtab (
    .clk     (clk),
    .rst     (rst),
    .we_i    (cfg_we_i),
    .waddr_i (cfg_line_i),
    .wdata_i (cfg_vec_i),
    .raddr_i (sel_idx),
    .rdata_o (tab_vec)
  );

  assign busy     = |isr_q;
  assign irq_o    = sel_vld & ~busy;
  assign accept   = ack_i & irq_o;
  assign pend_clr = accept ? sel_oh : '0;

  if (CASC_LINE >= 0 && CASC_LINE < N_LINES) begin : g_casc
    assign casc_hit = casc_en_i && (int'(sel_idx) == CASC_LINE);
  end else begin : g_nocasc
    assign casc_hit = 1'b0;
  end

  assign next_vec = casc_hit ? casc_vec_i : tab_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q <= '0;
      vec_q <= '0;
    end else if (accept) begin
      isr_q <= sel_oh;
      vec_q <= next_vec;
    end else if (eoi_i) begin
      isr_q <= '0;
    end
  end

  assign vec_o = vec_q;
endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
  parameter int N  = 8,
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          irq_o,
  input logic          accept,
  input logic          eoi_i,
  input logic [N-1:0]  pend_q,
  input logic [N-1:0]  isr_q,
  input logic [VW-1:0] vec_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pend_q == '0 && isr_q == '0 && vec_o == '0 && !irq_o));

  // R6
  busy_blocks_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (isr_q != '0) |-> !irq_o);

  // R6
  one_in_service_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(isr_q));

  // R4
  accept_sets_isr_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (isr_q != '0));

  // R6
  eoi_clears_isr_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_i && !accept) |=> (isr_q == '0));

  // R9
  vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(vec_o));
endmodule

bind vic_top vic_chk #(.N(N_LINES), .VW(VEC_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .irq_o  (irq_o),
  .accept (accept),
  .eoi_i  (eoi_i),
  .pend_q (pend_q),
  .isr_q  (isr_q),
  .vec_o  (vec_o)
);

// File: tb/vic_top_bench.sv
module vic_top_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] req;
  logic       irq;
  logic       ack;
  logic [7:0] vec;
  logic       eoi;
  logic       we;
  logic [2:0] wline;
  logic [7:0] wdata;
  logic       casc_en;
  logic [7:0] casc_vec;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // reference state
  bit [7:0] m_pend, m_isr, m_vec;
  bit [7:0] m_tab [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  vic_top u_vic_top (
    .clk(clk), .rst(rst), .req_i(req), .irq_o(irq), .ack_i(ack),
    .vec_o(vec), .eoi_i(eoi), .cfg_we_i(we), .cfg_line_i(wline),
    .cfg_vec_i(wdata), .casc_en_i(casc_en), .casc_vec_i(casc_vec)
  );

  function automatic bit m_irq();
    return (m_pend != 0) && (m_isr == 0);
  endfunction

  function automatic int m_pick();
    for (int i = 0; i < 8; i++) if (m_pend[i]) return i;
    return 0;
  endfunction

  task automatic quiet();
    rst = 0; req = 0; ack = 0; eoi = 0; we = 0; wline = 0; wdata = 0;
    casc_en = 0; casc_vec = 0;
  endtask

  task automatic model_step();
    bit       acc;
    int       s;
    bit [7:0] nv;
    if (rst) begin
      m_pend = 0; m_isr = 0; m_vec = 0;
      for (int i = 0; i < 8; i++) m_tab[i] = 8'(8 + i);
    end else begin
      acc = ack && m_irq();
      s   = m_pick();
      nv  = m_vec;
      if (acc) begin
        nv = (casc_en && s == 2) ? casc_vec : m_tab[s];
        m_pend[s] = 1'b0;
        m_isr = 8'(1 << s);
      end else if (eoi) begin
        m_isr = 0;
      end
      m_pend = m_pend | req;
      if (we) m_tab[wline] = wdata;
      m_vec = nv;
    end
  endtask

  // Apply the current inputs for one cycle, then compare.
  task automatic tick(input string tag);
    model_step();
    @(negedge clk);
    vectors++;
    if (irq !== m_irq()) begin
      errors++;
      $display("FAIL %s irq_o got %0b exp %0b", tag, irq, m_irq());
    end
    if (vec !== m_vec) begin
      errors++;
      $display("FAIL %s vec_o got %02h exp %02h", tag, vec, m_vec);
    end
  endtask

  task automatic serve(input string tag);
    quiet(); ack = 1; tick(tag);
    quiet(); eoi = 1; tick(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    quiet(); rst = 1;
    @(negedge clk);
    tick("R1 reset");
    tick("R1 reset");
    quiet(); tick("R1 idle after reset");

    // R1: every line reports its default type number
    for (int n = 0; n < 8; n++) begin
      quiet(); req = 8'(1 << n); tick("R2 request latched");
      serve("R1 default vector");
    end

    // R2, R4, R6
    quiet(); req = 8'h01; tick("R2 line0 pending");
    quiet(); ack = 1; tick("R4 accept line0");
    quiet(); req = 8'h08; tick("R6 request while busy");
    quiet(); tick("R6 still blocked");
    quiet(); eoi = 1; tick("R6 eoi releases");
    serve("R4 accept line3");

    // R3: simultaneous requests, priority order
    quiet(); req = 8'hB0; tick("R3 three at once");
    serve("R3 line4 first");
    serve("R3 line5 second");
    serve("R3 line7 last");

    // R5: acknowledge while idle
    quiet(); ack = 1; tick("R5 spurious ack");
    quiet(); ack = 1; tick("R5 spurious ack again");

    // R7: reprogram line 5
    quiet(); we = 1; wline = 3'd5; wdata = 8'h55; tick("R7 write");
    quiet(); req = 8'h20; tick("R7 request");
    serve("R7 new vector");

    // R8: cascade line
    quiet(); req = 8'h04; tick("R8 request line2");
    quiet(); casc_en = 1; casc_vec = 8'h70; ack = 1; tick("R8 cascade vector");
    quiet(); eoi = 1; tick("R8 eoi");
    quiet(); req = 8'h04; tick("R8 request line2");
    quiet(); ack = 1; casc_vec = 8'h71; tick("R8 own vector when disabled");
    quiet(); eoi = 1; tick("R8 eoi");

    // R10: request on the accepted line in the accept cycle
    quiet(); req = 8'h02; tick("R10 request line1");
    quiet(); req = 8'h02; ack = 1; tick("R10 accept with new request");
    quiet(); eoi = 1; tick("R10 still pending");
    serve("R10 second service");

    // R9, R4, R6: free-running mixed traffic
    for (int k = 0; k < 4000; k++) begin
      quiet();
      rst      = ($urandom_range(0, 499) == 0);
      req      = ($urandom_range(0, 3) == 0) ? 8'($urandom) & 8'($urandom) : 8'h00;
      ack      = ($urandom_range(0, 9) < 3);
      eoi      = ($urandom_range(0, 9) < 2);
      we       = ($urandom_range(0, 19) == 0);
      wline    = 3'($urandom);
      wdata    = 8'($urandom);
      casc_en  = $urandom_range(0, 1) == 1;
      casc_vec = 8'($urandom);
      tick("R9 R4 R6 mixed traffic");
    end

    finish_run();
  end
endmodule